// File: doc/BRIEF.md
# Coprocessor Escape Snooper and Hardwired-Control Decoder

This block sits beside a host processor and listens, without driving anything, to its instruction-fetch and data-read traffic. When the host fetches a byte whose upper five bits are `11011`, the block treats that byte as the start of a coprocessor instruction. It keeps that byte, takes the next fetched byte as the operand-mode byte, and tells from its two top bits whether the instruction names a memory operand or only internal registers.

For the memory form the host computes the effective address itself and issues one read whose data it discards. The snooper skips the displacement bytes that the mode field calls for, then latches the address of that next host read. It holds this address for the coprocessor's own later transfers. For the register form no address is taken and the instruction is reported at once.

A small two-stage decoder examines every fetched byte. The first stage looks at the upper five bits. The second stage combines that result with the lower three bits. Results from the first byte are stored and later combined with the second byte to pick out a handful of control instructions that are carried out by hardware rather than microcode. Short ones raise a one-cycle strobe. Long ones, which need a multi-transfer bus sequence, set a flag that stays high until the bus sequencer reports completion.

Top module: `escape_snooper`

## Requirements
- R1: While no instruction is in progress, a fetched byte with bits [7:3] = 11011 is latched into `op_first`; any other fetched byte leaves `op_first` unchanged and raises no `op_valid`.
- R2: The byte fetched right after an escape byte is latched into `op_modrm`, and `mem_form` is set to 1 when its bits [7:6] differ from 11, and to 0 otherwise.
- R3: When the mode field is 11, `op_valid` is high for exactly one cycle, starting on the clock edge that samples the mode byte, and `operand_addr` is left unchanged.
- R4: When the mode field is 00, 01 or 10, exactly 0, 1 or 2 following fetched bytes are skipped as displacement. These bytes and any later fetches are never taken as escapes. The address of the next data read is then latched into `operand_addr`, with a one-cycle `op_valid` on the same edge.
- R5: A data read that is not the awaited operand read of a memory-form escape leaves `operand_addr` unchanged.
- R6: The first-byte values D9, DB and DD and the second-byte values E0 to E3 are decoded. On the edge that samples the second byte, one bit of `hw_pulse` is high for exactly one cycle, together with `op_valid`. The bits are: DB E0 → bit 0, DB E1 → bit 1, DB E2 → bit 2, DB E3 → bit 3, D9 E0 → bit 4, D9 E1 → bit 5.
- R7: DD E0 sets `hw_busy[0]` and DD E1 sets `hw_busy[1]`. Each flag stays high until `seq_done` at the same index is sampled high, and then reads 0 in the following cycle.
- R8: Every other first/second byte pair raises no `hw_pulse` bit and no `hw_busy` bit. This includes D9 E2, DD E3, a non-listed escape with mode 11, and DD with a memory-form mode byte.
- R9: Synchronous active-high `rst` clears `op_first`, `op_modrm`, `operand_addr`, `mem_form`, `op_valid`, `hw_pulse` and `hw_busy`, and abandons any instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Host instruction-byte fetch strobe |
| fetch_byte | input | 8 | Fetched instruction byte |
| rd_valid | input | 1 | Host data-read strobe |
| rd_addr | input | ADDR_W | Address of the host data read |
| seq_done | input | 2 | Bus sequencer completion, one bit per busy flag |
| op_valid | output | 1 | One-cycle pulse: a coprocessor instruction has been fully captured |
| op_first | output | 8 | Latched escape byte |
| op_modrm | output | 8 | Latched operand-mode byte |
| mem_form | output | 1 | 1 when the latched instruction has a memory operand |
| operand_addr | output | ADDR_W | Latched operand address |
| hw_pulse | output | 6 | One-hot strobes for short hardwired instructions |
| hw_busy | output | 2 | Held flags for multi-transfer hardwired instructions |

## Verification
The displacement bytes are filled with the value DB, which matches the escape pattern. A design that miscounts them would restart on a displacement byte and corrupt `op_first`, or take the wrong read address. Stray reads before an escape and fetches during the wait for the operand read are driven to catch a design that overwrites the held address or decodes a phantom hardwired instruction. Pairs that are near misses check that the latched first-byte flags are combined correctly with the second byte. These include D9 E2, DD E3, DD with a memory mode byte, and a non-listed escape with mode 11. Busy flags are held over an idle cycle and then released, and a reset in the middle of a sequence must drop them along with the pending instruction.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam logic [4:0] ESC_HI = 5'b11011;
  localparam logic [4:0] EXT_HI = 5'b11100;
  localparam int NUM_PULSE = 6;
  localparam int NUM_BUSY  = 2;
  localparam int NUM_EXT   = 4;
  localparam int DISP_W    = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_MODRM, ST_DISP, ST_ARMED} snoop_st_e;

  typedef struct packed {
    logic is_d9;
    logic is_db;
    logic is_dd;
  } first_flags_t;
endpackage

// File: rtl/snoop_hi_dec.sv
module snoop_hi_dec
  import snoop_pkg::*;
(
  input  logic [4:0] hi_bits,
  output logic       hi_esc,
  output logic       hi_ext
);
  always_comb begin
    hi_esc = (hi_bits == ESC_HI);
    hi_ext = (hi_bits == EXT_HI);
  end
endmodule

// File: rtl/snoop_lo_dec.sv
module snoop_lo_dec
  import snoop_pkg::*;
(
  input  logic               hi_esc,
  input  logic               hi_ext,
  input  logic [2:0]         lo_bits,
  output first_flags_t       first_hit,
  output logic [NUM_EXT-1:0] ext_hit
);
  always_comb begin
    first_hit.is_d9 = hi_esc && (lo_bits == 3'd1);
    first_hit.is_db = hi_esc && (lo_bits == 3'd3);
    first_hit.is_dd = hi_esc && (lo_bits == 3'd5);
  end

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    assign ext_hit[g] = hi_ext && (lo_bits == 3'(g));
  end
endmodule

// File: rtl/snoop_seq.sv
module snoop_seq
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [7:0]        fetch_byte,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              hi_esc,
  input  first_flags_t      first_hit,
  output first_flags_t      first_q,
  output logic              reg_take,
  output logic              op_valid,
  output logic [7:0]        op_first,
  output logic [7:0]        op_modrm,
  output logic              mem_form,
  output logic [ADDR_W-1:0] operand_addr
);
  snoop_st_e         state;
  logic [DISP_W-1:0] disp_left;
  logic [1:0]        mod_f;

  assign mod_f    = fetch_byte[7:6];
  assign reg_take = (state == ST_MODRM) && fetch_valid && (mod_f == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      disp_left    <= '0;
      first_q      <= '0;
      op_valid     <= 1'b0;
      op_first     <= '0;
      op_modrm     <= '0;
      mem_form     <= 1'b0;
      operand_addr <= '0;
    end else begin
      op_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fetch_valid && hi_esc) begin
            op_first <= fetch_byte;
            first_q  <= first_hit;
            state    <= ST_MODRM;
          end
        end
        ST_MODRM: begin
          if (fetch_valid) begin
            op_modrm <= fetch_byte;
            mem_form <= (mod_f != 2'b11);
            if (mod_f == 2'b11) begin
              op_valid <= 1'b1;
              state    <= ST_IDLE;
            end else if (mod_f == 2'b00) begin
              state <= ST_ARMED;
            end else begin
              disp_left <= DISP_W'(mod_f);
              state     <= ST_DISP;
            end
          end
        end
        ST_DISP: begin
          if (fetch_valid) begin
            if (disp_left == DISP_W'(1)) state <= ST_ARMED;
            disp_left <= disp_left - DISP_W'(1);
          end
        end
        ST_ARMED: begin
          if (rd_valid) begin
            operand_addr <= rd_addr;
            op_valid     <= 1'b1;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_hw.sv
module snoop_hw
  import snoop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_take,
  input  first_flags_t         first_q,
  input  logic [NUM_EXT-1:0]   ext_hit,
  input  logic [NUM_BUSY-1:0]  seq_done,
  output logic [NUM_PULSE-1:0] hw_pulse,
  output logic [NUM_BUSY-1:0]  hw_busy
);
  logic [NUM_PULSE-1:0] pulse_d;
  logic [NUM_BUSY-1:0]  busy_set;

  always_comb begin
    pulse_d       = '0;
    pulse_d[3:0]  = {4{reg_take && first_q.is_db}} & ext_hit;
    pulse_d[5:4]  = {2{reg_take && first_q.is_d9}} & ext_hit[1:0];
  end

  for (genvar g = 0; g < NUM_BUSY; g++) begin : g_busy
    assign busy_set[g] = reg_take && first_q.is_dd && ext_hit[g];
    always_ff @(posedge clk) begin
      if (rst)              hw_busy[g] <= 1'b0;
      else if (busy_set[g]) hw_busy[g] <= 1'b1;
      else if (seq_done[g]) hw_busy[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hw_pulse <= '0;
    else     hw_pulse <= pulse_d;
  end
endmodule

// File: rtl/escape_snooper.sv
module escape_snooper
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_valid,
  input  logic [7:0]           fetch_byte,
  input  logic                 rd_valid,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NUM_BUSY-1:0]  seq_done,
  output logic                 op_valid,
  output logic [7:0]           op_first,
  output logic [7:0]           op_modrm,
  output logic                 mem_form,
  output logic [ADDR_W-1:0]    operand_addr,
  output logic [NUM_PULSE-1:0] hw_pulse,
  output logic [NUM_BUSY-1:0]  hw_busy
);
  logic               hi_esc, hi_ext, reg_take;
  first_flags_t       first_hit, first_q;
  logic [NUM_EXT-1:0] ext_hit;

  snoop_hi_dec u_hi (
    .hi_bits (fetch_byte[7:3]),
    .hi_esc  (hi_esc),
    .hi_ext  (hi_ext)
  );

  snoop_lo_dec u_lo (
    .hi_esc    (hi_esc),
    .hi_ext    (hi_ext),
    .lo_bits   (fetch_byte[2:0]),
    .first_hit (first_hit),
    .ext_hit   (ext_hit)
  );

  snoop_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .fetch_byte   (fetch_byte),
    .rd_valid     (rd_valid),
    .rd_addr      (rd_addr),
    .hi_esc       (hi_esc),
    .first_hit    (first_hit),
    .first_q      (first_q),
    .reg_take     (reg_take),
    .op_valid     (op_valid),
    .op_first     (op_first),
    .op_modrm     (op_modrm),
    .mem_form     (mem_form),
    .operand_addr (operand_addr)
  );

  snoop_hw u_hw (
    .clk      (clk),
    .rst      (rst),
    .reg_take (reg_take),
    .first_q  (first_q),
    .ext_hit  (ext_hit),
    .seq_done (seq_done),
    .hw_pulse (hw_pulse),
    .hw_busy  (hw_busy)
  );
endmodule

// File: rtl/escape_snooper_chk.sv
module escape_snooper_chk
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BUSY-1:0]  seq_done,
  input logic                 op_valid,
  input logic [7:0]           op_modrm,
  input logic                 mem_form,
  input logic [ADDR_W-1:0]    operand_addr,
  input logic [NUM_PULSE-1:0] hw_pulse,
  input logic [NUM_BUSY-1:0]  hw_busy
);
  assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);

  assert_form_flag_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (mem_form == (op_modrm[7:6] != 2'b11)));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(operand_addr) |-> (op_valid && mem_form));

  assert_pulse_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hw_pulse));

  assert_pulse_with_op_R6: assert property (@(posedge clk) disable iff (rst)
    (hw_pulse != '0) |-> (op_valid && !mem_form));

  assert_busy0_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (hw_busy[0] && !seq_done[0]) |=> hw_busy[0]);

  assert_busy1_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (hw_busy[1] && !seq_done[1]) |=> hw_busy[1]);
endmodule

bind escape_snooper escape_snooper_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .seq_done     (seq_done),
  .op_valid     (op_valid),
  .op_modrm     (op_modrm),
  .mem_form     (mem_form),
  .operand_addr (operand_addr),
  .hw_pulse     (hw_pulse),
  .hw_busy      (hw_busy)
);

// File: tb/escape_snooper_bench.sv
module escape_snooper_bench;
  localparam int ADDR_W = 20;
  localparam int NV = 13;
  // {first[43:36], second[35:28], addr[27:8], pulse[7:2], busy[1:0]}
  localparam logic [43:0] VECS [NV] = '{
    {8'hDB, 8'hE0, 20'h00000, 6'b000001, 2'b00},
    {8'hDB, 8'hE1, 20'h00000, 6'b000010, 2'b00},
    {8'hDB, 8'hE2, 20'h00000, 6'b000100, 2'b00},
    {8'hDB, 8'hE3, 20'h00000, 6'b001000, 2'b00},
    {8'hD9, 8'hE0, 20'h00000, 6'b010000, 2'b00},
    {8'hD9, 8'hE1, 20'h00000, 6'b100000, 2'b00},
    {8'hDD, 8'hE0, 20'h00000, 6'b000000, 2'b01},
    {8'hDD, 8'hE1, 20'h00000, 6'b000000, 2'b10},
    {8'hD9, 8'hE2, 20'h00000, 6'b000000, 2'b00},
    {8'hD8, 8'hC1, 20'h00000, 6'b000000, 2'b00},
    {8'hD8, 8'h06, 20'h12345, 6'b000000, 2'b00},
    {8'hDC, 8'h45, 20'hABCDE, 6'b000000, 2'b00},
    {8'hDD, 8'hA0, 20'h0F00D, 6'b000000, 2'b00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_valid = 1'b0, rd_valid = 1'b0;
  logic [7:0] fetch_byte = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [1:0] seq_done = '0;
  logic op_valid, mem_form;
  logic [7:0] op_first, op_modrm;
  logic [ADDR_W-1:0] operand_addr;
  logic [5:0] hw_pulse;
  logic [1:0] hw_busy;
  int n_chk = 0, n_fail = 0;
  logic [ADDR_W-1:0] last_addr = '0;

  always #10 clk = ~clk;

  escape_snooper #(.ADDR_W(ADDR_W)) u_escape_snooper (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [7:0] b);
    @(negedge clk); fetch_valid = 1'b1; fetch_byte = b;
    @(negedge clk); fetch_valid = 1'b0;
  endtask

  task automatic hread(input logic [ADDR_W-1:0] a);
    @(negedge clk); rd_valid = 1'b1; rd_addr = a;
    @(negedge clk); rd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    check("R9 op_first", op_first, 0); check("R9 op_modrm", op_modrm, 0);
    check("R9 addr", operand_addr, 0); check("R9 valid", op_valid, 0);
    check("R9 mem_form", mem_form, 0); check("R9 pulse", hw_pulse, 0);
    check("R9 busy", hw_busy, 0);

    // R5 stray read while idle
    hread(20'h55555);
    check("R5 stray read", operand_addr, 0);
    check("R5 no valid", op_valid, 0);
    // R1 non-escape bytes
    fetch(8'h90); check("R1 non-escape", op_first, 0);
    fetch(8'hD7); check("R1 near miss", op_first, 0);
    fetch(8'hE0); check("R1 E0 alone", hw_pulse, 0);
    check("R1 no valid", op_valid, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] b0, b1; logic [ADDR_W-1:0] ad; logic [5:0] pl; logic [1:0] bz;
      {b0, b1, ad, pl, bz} = VECS[v];
      fetch(b0);
      check("R1 latched", op_first, 32'(b0));
      fetch(b1);
      check("R2 modrm", op_modrm, 32'(b1));
      check("R2 form", mem_form, 32'(b1[7:6] != 2'b11));
      if (b1[7:6] == 2'b11) begin
        check("R3 valid", op_valid, 1);
        check("R3 addr kept", operand_addr, 32'(last_addr));
        check("R6 R8 pulse", hw_pulse, 32'(pl));
        check("R7 R8 busy", hw_busy, 32'(bz));
      end else begin
        check("R4 wait", op_valid, 0);
        for (int d = 0; d < int'(b1[7:6]); d++) begin
          fetch(8'hDB);
          check("R4 disp not taken", op_valid, 0);
        end
        fetch(8'hD9); fetch(8'hE0); // fetches during wait ignored
        check("R4 wait fetch", op_first, 32'(b0));
        check("R8 no pulse wait", hw_pulse, 0);
        hread(ad);
        last_addr = ad;
        check("R4 valid", op_valid, 1);
        check("R4 addr", operand_addr, 32'(ad));
        check("R8 mem no busy", hw_busy, 0);
        check("R8 mem no pulse", hw_pulse, 0);
      end
      @(negedge clk);
      check("R3 one cycle", op_valid, 0);
      check("R6 one cycle", hw_pulse, 0);
      if (bz != 0) begin
        check("R7 held", hw_busy, 32'(bz));
        seq_done = bz;
        @(negedge clk); seq_done = '0;
        check("R7 released", hw_busy, 0);
      end
      hread(20'h77777);
      check("R5 read after op", operand_addr, 32'(last_addr));
    end

    // R8 DD E3 and back-to-back escapes
    fetch(8'hDD); fetch(8'hE3);
    check("R8 DD E3", {hw_pulse, hw_busy}, 0);
    fetch(8'hDB); fetch(8'hE2);
    check("R6 back-to-back", hw_pulse, 32'h04);

    // R9 reset mid-sequence clears busy and pending capture
    fetch(8'hDD); fetch(8'hE1);
    check("R7 set", hw_busy, 2'b10);
    fetch(8'hD8); fetch(8'h46);
    do_reset();
    check("R9 busy cleared", hw_busy, 0);
    check("R9 addr cleared", operand_addr, 0);
    hread(20'h33333);
    check("R9 pending dropped", operand_addr, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule